// File: doc/BRIEF.md
# Permission-Checking Translation Lookaside Buffer

This block translates virtual addresses to physical addresses for a physically addressed cache. Each request carries a virtual address and an access kind (read or write). The block searches a small fully associative set of translation entries. When an entry matches and its permission bits allow the access, it returns the physical address. When an entry matches but forbids the access, it signals a protection fault. When nothing matches, it signals a miss and asks an external page-table walker for the translation.

The walker later supplies a refill entry. The refill goes into an empty slot if there is one; otherwise a round-robin pointer picks the slot to overwrite. The retried access then hits. A flush input empties the whole buffer in one cycle. Every lookup result is registered, so it appears one cycle after the request.

Top module: `tlb_guard`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` and `walk_req` are low, and the first lookup reports a miss.
- R2: A request accepted on a clock edge (`req_valid` high) gives `rsp_valid` high on the next cycle, with exactly one of `rsp_hit`, `rsp_fault`, `rsp_miss` set. With no request, `rsp_valid` and all three flags are low the cycle after.
- R3: On an allowed hit, `rsp_pa` equals the entry's physical page number in bits [31:12], followed by the request's 12-bit page offset in bits [11:0].
- R4: A read (`req_write`=0) needs the entry's read bit, and a write (`req_write`=1) needs its write bit. A matched entry lacking the needed bit gives `rsp_fault` and `rsp_pa`=0.
- R5: A miss gives `rsp_pa`=0. It raises `walk_req` for exactly the response cycle, with `walk_vpn` equal to request address bits [31:12].
- R6: After a refill (`fill_valid`) of the missing page number, the same access hits with the refilled translation.
- R7: A refill goes to the lowest-numbered invalid entry while any entry is invalid, and the round-robin pointer does not move.
- R8: When all entries are valid, a refill overwrites the entry at the round-robin pointer. The pointer is 0 after reset, advances by one (modulo the entry count) after each such refill, and is not cleared by a flush.
- R9: `flush` invalidates every entry at the next edge. A refill in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a refill is resolved against the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address of the request |
| req_write | input | 1 | Access kind: 1 = write, 0 = read |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Refill entry strobe from the walker |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_miss | output | 1 | No translation present |
| rsp_pa | output | 32 | Physical address (zero unless hit) |
| walk_req | output | 1 | Request to the page-table walker |
| walk_vpn | output | 20 | Page number the walker must fetch |

## Verification
The assertion that at most one entry matches a page number assumes the walker never refills a page number that is already resident. The bench only refills page numbers that just missed or that are not loaded since the last flush. The replacement checks assume a refill is never issued while a flush is asserted. The one directed case that breaks this rule checks that the refill is dropped.

// File: rtl/tlb_guard_pkg.sv
package tlb_guard_pkg;

   typedef enum logic [1:0] {
      OUT_NONE  = 2'd0,
      OUT_HIT   = 2'd1,
      OUT_FAULT = 2'd2,
      OUT_MISS  = 2'd3
   } outcome_e;

   function automatic logic access_allowed(input logic may_rd,
                                           input logic may_wr,
                                           input logic is_write);
      return is_write ? may_wr : may_rd;
   endfunction

endpackage

// File: rtl/tlb_guard_store.sv
module tlb_guard_store #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic               wr_rd,
   input  logic               wr_wr,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic [ENTRIES-1:0] valid_vec,
   output logic               lk_match,
   output logic [PPN_W-1:0]   lk_ppn,
   output logic               lk_rd,
   output logic               lk_wr
);

   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic [ENTRIES-1:0] rd_q;
   logic [ENTRIES-1:0] wr_q;
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            vpn_q[e]   <= '0;
            ppn_q[e]   <= '0;
            rd_q[e]    <= 1'b0;
            wr_q[e]    <= 1'b0;
         end else if (flush) begin
            valid_q[e] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            valid_q[e] <= 1'b1;
            vpn_q[e]   <= wr_vpn;
            ppn_q[e]   <= wr_ppn;
            rd_q[e]    <= wr_rd;
            wr_q[e]    <= wr_wr;
         end
      end
      assign hit_vec[e] = valid_q[e] && (vpn_q[e] == lk_vpn);
   end

   always_comb begin
      lk_ppn = '0;
      lk_rd  = 1'b0;
      lk_wr  = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit_vec[e]) begin
            lk_ppn = lk_ppn | ppn_q[e];
            lk_rd  = lk_rd  | rd_q[e];
            lk_wr  = lk_wr  | wr_q[e];
         end
      end
   end

   assign lk_match  = |hit_vec;
   assign valid_vec = valid_q;

   // R9: a flush leaves no valid entry behind
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));

   // Stimulus contract: a page number is resident at most once
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_vec) <= 1);

endmodule

// File: rtl/tlb_guard_victim.sv
module tlb_guard_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               fill_fire,
   output logic [IDX_W-1:0]   victim_idx
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_next;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;
   logic             full;

   assign full = &valid_vec;

   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) begin
            free_idx = IDX_W'(e);
            any_free = 1'b1;
         end
      end
   end

   if ((1 << IDX_W) == ENTRIES) begin : g_wrap_pow2
      assign rr_next = rr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_next = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rr_q <= '0;
      else if (fill_fire && full) rr_q <= rr_next;
   end

   assign victim_idx = any_free ? free_idx : rr_q;

   // R7: while a slot is free, the chosen slot is a free one
   a_r7_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> !valid_vec[victim_idx]);

   // R7: the pointer holds while free slots remain
   a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_fire && full) |=> $stable(rr_q));

   // R8: the pointer steps by one after each refill into a full buffer
   a_r8_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_fire && full) |=>
         (rr_q == ((32'($past(rr_q)) == ENTRIES - 1) ? '0 : $past(rr_q) + 1'b1)));

endmodule

// File: rtl/tlb_guard.sv
module tlb_guard #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic             flush,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_fault,
   output logic             rsp_miss,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn
);
   import tlb_guard_pkg::*;

   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_guard: PAGE_BITS must lie inside both address widths");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("tlb_guard: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] valid_vec;
   logic [IDX_W-1:0]   victim_idx;
   logic               lk_match, lk_rd, lk_wr;
   logic [PPN_W-1:0]   lk_ppn;
   logic               fill_fire;
   logic [VPN_W-1:0]   req_vpn;
   outcome_e           outcome;

   assign req_vpn   = req_va[VA_W-1:PAGE_BITS];
   assign fill_fire = fill_valid && !flush;

   tlb_guard_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (fill_fire),
      .wr_idx    (victim_idx),
      .wr_vpn    (fill_vpn),
      .wr_ppn    (fill_ppn),
      .wr_rd     (fill_rd),
      .wr_wr     (fill_wr),
      .lk_vpn    (req_vpn),
      .valid_vec (valid_vec),
      .lk_match  (lk_match),
      .lk_ppn    (lk_ppn),
      .lk_rd     (lk_rd),
      .lk_wr     (lk_wr)
   );

   tlb_guard_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_vec),
      .fill_fire  (fill_fire),
      .victim_idx (victim_idx)
   );

   always_comb begin
      if (!req_valid)                                  outcome = OUT_NONE;
      else if (!lk_match)                              outcome = OUT_MISS;
      else if (access_allowed(lk_rd, lk_wr, req_write)) outcome = OUT_HIT;
      else                                             outcome = OUT_FAULT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_pa    <= '0;
         walk_req  <= 1'b0;
         walk_vpn  <= '0;
      end else begin
         rsp_valid <= (outcome != OUT_NONE);
         rsp_hit   <= (outcome == OUT_HIT);
         rsp_fault <= (outcome == OUT_FAULT);
         rsp_miss  <= (outcome == OUT_MISS);
         rsp_pa    <= (outcome == OUT_HIT) ? {lk_ppn, req_va[PAGE_BITS-1:0]} : '0;
         walk_req  <= (outcome == OUT_MISS);
         if (outcome == OUT_MISS) walk_vpn <= req_vpn;
      end
   end

   // R2: a request is answered on the next cycle
   a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2: no answer without a request
   a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_valid || rsp_hit || rsp_fault || rsp_miss));

   // R2: exactly one outcome flag while valid
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_fault, rsp_miss}));

   // R3: the page offset passes through untranslated
   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0])));

   // R4: a fault carries no address
   a_r4_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_pa == '0));

   // R5: walker request accompanies exactly the miss responses
   a_r5_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> (rsp_valid && rsp_miss && rsp_pa == '0));

   a_r5_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> walk_req);

endmodule

// File: tb/tlb_guard_bench.sv
module tlb_guard_bench;

   localparam int KIND_HIT   = 0;
   localparam int KIND_FAULT = 1;
   localparam int KIND_MISS  = 2;

   typedef struct packed {
      logic [31:0] va;
      logic        wr;
      logic [1:0]  kind;
      logic [31:0] pa;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{va: 32'h0001_0ABC, wr: 1'b0, kind: 2'd0, pa: 32'h8001_0ABC},
      '{va: 32'h0001_0FFF, wr: 1'b1, kind: 2'd0, pa: 32'h8001_0FFF},
      '{va: 32'h0001_1000, wr: 1'b0, kind: 2'd0, pa: 32'h80AA_1000},
      '{va: 32'h0001_1234, wr: 1'b1, kind: 2'd1, pa: 32'h0000_0000},
      '{va: 32'h0001_2010, wr: 1'b1, kind: 2'd0, pa: 32'h7FF0_0010},
      '{va: 32'h0001_2010, wr: 1'b0, kind: 2'd1, pa: 32'h0000_0000},
      '{va: 32'hFFFF_F123, wr: 1'b0, kind: 2'd0, pa: 32'h0000_1123},
      '{va: 32'h0001_3000, wr: 1'b0, kind: 2'd2, pa: 32'h0000_0000},
      '{va: 32'h0000_0000, wr: 1'b1, kind: 2'd2, pa: 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        flush = 1'b0;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic        fill_rd = 1'b0;
   logic        fill_wr = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss, walk_req;
   logic [31:0] rsp_pa;
   logic [19:0] walk_vpn;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   tlb_guard u_tlb_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .flush(flush), .fill_valid(fill_valid),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .walk_req(walk_req), .walk_vpn(walk_vpn)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drives one lookup and checks the registered answer a cycle later.
   task automatic lookup(input logic [31:0] va, input logic wr, input int kind,
                         input logic [31:0] pa, input string req);
      logic [2:0] flags, exp_flags;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      flags     = {rsp_hit, rsp_fault, rsp_miss};
      exp_flags = (kind == KIND_HIT) ? 3'b100 : (kind == KIND_FAULT) ? 3'b010 : 3'b001;
      check(rsp_valid && flags == exp_flags, req, 64'({rsp_valid, flags}), 64'({1'b1, exp_flags}));
      check(rsp_pa == pa, req, 64'(rsp_pa), 64'(pa));
      check(walk_req == (kind == KIND_MISS), req, 64'(walk_req), 64'(kind == KIND_MISS));
      if (kind == KIND_MISS) check(walk_vpn == va[31:12], req, 64'(walk_vpn), 64'(va[31:12]));
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic rd, input logic wr);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs in and after reset
      check(!rsp_valid && !walk_req, "R1", 64'({rsp_valid, walk_req}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rsp_valid && !walk_req, "R1", 64'({rsp_valid, walk_req}), 64'd0);
      lookup(32'h0001_0ABC, 1'b0, KIND_MISS, 32'h0, "R1 empty after reset");

      refill(20'h00010, 20'h80010, 1'b1, 1'b1);
      refill(20'h00011, 20'h80AA1, 1'b1, 1'b0);
      refill(20'h00012, 20'h7FF00, 1'b0, 1'b1);
      refill(20'hFFFFF, 20'h00001, 1'b1, 1'b1);

      // R2 R3 R4 R5 over the vector table
      for (int i = 0; i < NVEC; i++) begin
         lookup(VECS[i].va, VECS[i].wr, int'(VECS[i].kind), VECS[i].pa,
                $sformatf("R2/R3/R4/R5 vec %0d", i));
      end

      // R5: walk_req lasts one cycle only
      @(negedge clk);
      check(!walk_req && !rsp_valid, "R5 pulse width", 64'({walk_req, rsp_valid}), 64'd0);

      // R6: refill then retry
      lookup(32'h0001_3008, 1'b1, KIND_MISS, 32'h0, "R6 before refill");
      refill(20'h00013, 20'h12345, 1'b1, 1'b1);
      lookup(32'h0001_3008, 1'b1, KIND_HIT, 32'h1234_5008, "R6 retry");

      // R10: lookup in the refill cycle sees old contents
      @(negedge clk);
      req_valid = 1'b1; req_va = 32'h0001_4ABC; req_write = 1'b0;
      fill_valid = 1'b1; fill_vpn = 20'h00014; fill_ppn = 20'h00444; fill_rd = 1'b1; fill_wr = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0;
      check(rsp_valid && rsp_miss, "R10 same-cycle refill", 64'({rsp_valid, rsp_miss}), 64'd3);
      lookup(32'h0001_4ABC, 1'b0, KIND_HIT, 32'h0044_4ABC, "R10 after refill");

      // R7: fill to capacity, nothing evicted yet
      refill(20'h00015, 20'h00555, 1'b1, 1'b1);
      refill(20'h00016, 20'h00666, 1'b1, 1'b1);
      lookup(32'h0001_0000, 1'b0, KIND_HIT, 32'h8001_0000, "R7 slot0 kept");
      lookup(32'h0001_6001, 1'b0, KIND_HIT, 32'h0066_6001, "R7 slot7 filled");

      // R8: round-robin eviction starts at slot 0
      refill(20'h00020, 20'h00200, 1'b1, 1'b1);
      lookup(32'h0001_0000, 1'b0, KIND_MISS, 32'h0, "R8 slot0 evicted");
      lookup(32'h0001_1000, 1'b0, KIND_HIT, 32'h80AA_1000, "R8 slot1 kept");
      lookup(32'h0002_0010, 1'b0, KIND_HIT, 32'h0020_0010, "R8 new entry");
      refill(20'h00021, 20'h00210, 1'b1, 1'b1);
      lookup(32'h0001_1000, 1'b0, KIND_MISS, 32'h0, "R8 slot1 evicted");
      lookup(32'h0001_2000, 1'b1, KIND_HIT, 32'h7FF0_0000, "R8 slot2 kept");

      // R9: flush empties, and a fill during flush is dropped
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      lookup(32'h0002_0010, 1'b0, KIND_MISS, 32'h0, "R9 flushed");
      @(negedge clk);
      flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00030; fill_ppn = 20'h00300;
      fill_rd = 1'b1; fill_wr = 1'b1;
      @(negedge clk);
      flush = 1'b0; fill_valid = 1'b0;
      lookup(32'h0003_0000, 1'b0, KIND_MISS, 32'h0, "R9 fill dropped");

      // R7 R8: after flush free slots are used in order, pointer kept at 2
      for (int k = 0; k < 8; k++) refill(20'h00040 + 20'(k), 20'h00A00 + 20'(k), 1'b1, 1'b1);
      refill(20'h00048, 20'h00B00, 1'b1, 1'b1);
      lookup(32'h0004_2000, 1'b0, KIND_MISS, 32'h0, "R8 pointer survives flush");
      lookup(32'h0004_0000, 1'b0, KIND_HIT, 32'h00A0_0000, "R7 slot0 after flush");
      lookup(32'h0004_3000, 1'b0, KIND_HIT, 32'h00A0_3000, "R7 slot3 after flush");
      lookup(32'h0004_8FFF, 1'b0, KIND_HIT, 32'h00B0_0FFF, "R8 replaced slot");

      summary();
   end

endmodule